// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block holds the five status conditions of a network controller that are allowed to raise an interrupt, an 8-bit interrupt mask, and the logic that combines them into one registered interrupt line. Condition logic elsewhere in the controller raises a flag with a one-cycle set pulse. The flag then stays up until its own clearing event occurs. Each flag has a different clearing event: a command byte with the matching opcode or flag bit, or a read of the next-ID register.

Software reaches the block through a 2-bit byte offset with single-cycle write and read strobes. Offset 0 is the mask. Offset 1 takes command bytes. Offset 2 shows the latched flags. Offset 3 returns the next-ID value from outside the block. Masking only gates the interrupt output. A masked flag keeps its state and asserts the interrupt again as soon as its mask bit is set, provided the flag has not been cleared in the meantime.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, the mask, every flag and `irq_o` are 0.
- R2: A write to offset 0 stores only mask bits 7, 3, 2, 1 and 0. Reading offset 0 returns the mask, and all other bits read as 0.
- R3: A set pulse latches its flag at a fixed position in the status byte at offset 2: receiver-inhibited at bit 7, excessive-NAK at bit 3, reconfiguration at bit 2, new-next-ID at bit 1 and transmitter-available at bit 0. Every other status bit reads 0.
- R4: `irq_o` is the registered OR of each flag ANDed with the mask bit in the same position. It changes one clock after the flag or mask register changes.
- R5: Clearing a mask bit drops the interrupt but leaves the flag set. Setting the mask bit again raises `irq_o` again if the flag is still set.
- R6: A command write to offset 1 with opcode `wdata[2:0]`=3'b001 clears the reconfiguration flag when `wdata[3]` is 1 and the excessive-NAK flag when `wdata[4]` is 1. The two bits act independently.
- R7: Opcode 3'b010 clears the transmitter-available flag and opcode 3'b011 clears the receiver-inhibited flag. Any other opcode clears nothing, and writes to offsets 2 and 3 have no effect.
- R8: A read strobe at offset 3 returns `next_id_i` and clears the new-next-ID flag. Addressing offset 3 without the read strobe leaves the flag unchanged.
- R9: When a set pulse and a clearing event for the same flag fall in the same cycle, the flag ends up set.
- R10: Command writes never change the mask. Only the hardware reset and writes to offset 0 change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| set_ri_i | input | 1 | Set pulse, receiver inhibited |
| set_excnak_i | input | 1 | Set pulse, excessive NAK |
| set_recon_i | input | 1 | Set pulse, reconfiguration timer |
| set_nnid_i | input | 1 | Set pulse, new next ID |
| set_ta_i | input | 1 | Set pulse, transmitter available |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Byte offset |
| wdata_i | input | 8 | Write data |
| next_id_i | input | 8 | Next-ID value returned at offset 3 |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a set pulse that arrives in the same cycle as the clearing event for that flag. The only way to see the result is the status byte read afterwards. The bench drives this collision directly for the transmitter-available flag and for the new-next-ID flag, then reads offset 2. The masked-but-pending state is reached by first setting a flag, then writing a mask without its bit, then writing the mask with its bit again. `irq_o` is sampled after each of these writes, and the status byte is checked to confirm the flag was never cleared.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_FLAGS = 5;
  // compact flag indices
  localparam int F_TA     = 0;
  localparam int F_NNID   = 1;
  localparam int F_RECON  = 2;
  localparam int F_EXCNAK = 3;
  localparam int F_RI     = 4;
  localparam logic [DATA_W-1:0] VALID_BITS = 8'h8F;
  localparam logic [ADDR_W-1:0] OFS_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_NID  = 2'd3;
  typedef enum logic [2:0] {
    OP_NONE   = 3'b000,
    OP_CLRFLG = 3'b001,
    OP_EN_TX  = 3'b010,
    OP_EN_RX  = 3'b011
  } cmd_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set has priority
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & VALID;
  end
  assign mask_o = mask_q;

  a_r2_mask_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_o == ($past(wdata_i) & VALID)));
  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
  import stat_irq_pkg::*;
(
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [4:0]        cmd_i,
  output logic [NUM_FLAGS-1:0] clr_o
);
  cmd_op_e op;
  assign op = cmd_op_e'(cmd_i[2:0]);

  always_comb begin
    clr_o = '0;
    if (wr_en_i && addr_i == OFS_CMD) begin
      unique case (op)
        OP_CLRFLG: begin
          clr_o[F_RECON]  = cmd_i[3];
          clr_o[F_EXCNAK] = cmd_i[4];
        end
        OP_EN_TX: clr_o[F_TA] = 1'b1;
        OP_EN_RX: clr_o[F_RI] = 1'b1;
        default:  clr_o = '0;
      endcase
    end
    if (rd_en_i && addr_i == OFS_NID) clr_o[F_NNID] = 1'b1;
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_ri_i,
  input  logic              set_excnak_i,
  input  logic              set_recon_i,
  input  logic              set_nnid_i,
  input  logic              set_ta_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] next_id_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v, mask_v;
  logic [DATA_W-1:0]    mask_q, stat_b;
  logic                 irq_q;

  always_comb begin
    set_v = '0;
    set_v[F_RI]     = set_ri_i;
    set_v[F_EXCNAK] = set_excnak_i;
    set_v[F_RECON]  = set_recon_i;
    set_v[F_NNID]   = set_nnid_i;
    set_v[F_TA]     = set_ta_i;
  end

  irq_clr_decode u_dec (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .cmd_i   (wdata_i[4:0]),
    .clr_o   (clr_v)
  );

  irq_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_v)
  );

  irq_mask_reg #(.W(DATA_W), .VALID(VALID_BITS)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && addr_i == OFS_MASK),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  // status byte layout: RI at 7, flags 3..0 in place
  assign stat_b = {flag_v[F_RI], 3'b000, flag_v[F_EXCNAK], flag_v[F_RECON],
                   flag_v[F_NNID], flag_v[F_TA]};
  assign mask_v = {mask_q[7], mask_q[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_v & mask_v);
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (addr_i)
      OFS_MASK: rdata_o = mask_q;
      OFS_STAT: rdata_o = stat_b;
      OFS_NID:  rdata_o = next_id_i;
      default:  rdata_o = '0;
    endcase
  end

  a_r3_stat_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_STAT) |-> ((rdata_o & ~VALID_BITS) == '0));
  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_MASK && wdata_i == '0) |=> ##1 !irq_o);
  a_r4_no_source_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
endmodule

// File: tb/stat_irq_ctrl_test.sv
module stat_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_ri = 0, s_exc = 0, s_rec = 0, s_nn = 0, s_ta = 0;
  logic       wr = 0, rd = 0;
  logic [1:0] addr = 2'd2;
  logic [7:0] wdata = 8'h00, nid = 8'h5A;
  logic [7:0] rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  stat_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .set_ri_i(s_ri), .set_excnak_i(s_exc), .set_recon_i(s_rec),
    .set_nnid_i(s_nn), .set_ta_i(s_ta),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .next_id_i(nid), .rdata_o(rdata), .irq_o(irq)
  );

  // {wr, rd, addr[1:0], wdata[7:0], set{ri,exc,rec,nn,ta}, exp_stat[7:0], exp_irq}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,2'd2,8'h00,5'b11111,8'h8F,1'b0}, // R3 all five set, mask 0
    {1'b1,1'b0,2'd0,8'hFF,5'b00000,8'h8F,1'b1}, // R4 unmask all
    {1'b1,1'b0,2'd1,8'h09,5'b00000,8'h8B,1'b1}, // R6 clear recon
    {1'b1,1'b0,2'd1,8'h11,5'b00000,8'h83,1'b1}, // R6 clear excnak
    {1'b1,1'b0,2'd1,8'h02,5'b00000,8'h82,1'b1}, // R7 enable tx
    {1'b1,1'b0,2'd1,8'h03,5'b00000,8'h02,1'b1}, // R7 enable rx
    {1'b0,1'b1,2'd3,8'h00,5'b00000,8'h00,1'b0}, // R8 read next-id
    {1'b0,1'b0,2'd2,8'h00,5'b00001,8'h01,1'b1}, // R3 ta set
    {1'b1,1'b0,2'd0,8'h80,5'b00000,8'h01,1'b0}, // R5 hidden, kept
    {1'b1,1'b0,2'd0,8'h01,5'b00000,8'h01,1'b1}, // R5 reappears
    {1'b1,1'b0,2'd1,8'h07,5'b00000,8'h01,1'b1}, // R7 unused opcode
    {1'b1,1'b0,2'd2,8'h00,5'b00000,8'h01,1'b1}, // R7 write to status ignored
    {1'b1,1'b0,2'd1,8'h02,5'b00000,8'h00,1'b0}, // R7 enable tx
    {1'b0,1'b0,2'd2,8'h00,5'b10000,8'h80,1'b0}  // R4 ri set but masked
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr = 0; rd = 0; addr = 2'd2; wdata = 8'h00;
    {s_ri, s_exc, s_rec, s_nn, s_ta} = 5'b0;
  endtask

  task automatic drive(input logic [25:0] v);
    {wr, rd, addr, wdata, s_ri, s_exc, s_rec, s_nn, s_ta} = v[25:9];
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = 2'd0; #1; chk("R1 mask", rdata, 8'h00);
    addr = 2'd2; #1; chk("R1 stat", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); drive(VEC[i]);
      @(negedge clk); idle();
      @(negedge clk);
      chk($sformatf("vec%0d stat", i), rdata, VEC[i][8:1]);
      chk($sformatf("vec%0d irq", i), {7'b0, irq}, {7'b0, VEC[i][0]});
    end

    // R2 undefined mask bits read as 0
    @(negedge clk); wr = 1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk); idle(); addr = 2'd0; #1;
    chk("R2 mask readback", rdata, 8'h8F);
    // R10 commands leave mask alone
    @(negedge clk); wr = 1; addr = 2'd1; wdata = 8'h19;
    @(negedge clk); wr = 1; addr = 2'd1; wdata = 8'h03;
    @(negedge clk); idle(); addr = 2'd0; #1;
    chk("R10 mask after cmds", rdata, 8'h8F);

    // R9 set and enable-tx in same cycle
    @(negedge clk); wr = 1; addr = 2'd1; wdata = 8'h02; s_ta = 1;
    @(negedge clk); idle(); #1;
    chk("R9 ta set wins", rdata & 8'h01, 8'h01);
    // R9 nnid set during next-id read
    @(negedge clk); rd = 1; addr = 2'd3; s_nn = 1;
    @(negedge clk); idle(); #1;
    chk("R9 nnid set wins", rdata & 8'h02, 8'h02);

    // R8 addressing offset 3 without strobe keeps flag; read returns next_id
    @(negedge clk); addr = 2'd3; nid = 8'hC3; #1;
    chk("R8 next id data", rdata, 8'hC3);
    @(negedge clk); addr = 2'd2; #1;
    chk("R8 no strobe keeps", rdata & 8'h02, 8'h02);
    @(negedge clk); rd = 1; addr = 2'd3;
    @(negedge clk); idle(); #1;
    chk("R8 strobe clears", rdata & 8'h02, 8'h00);

    // R4 timing: clear ta, mask only ta, then set ta pulse
    @(negedge clk); wr = 1; addr = 2'd1; wdata = 8'h02;
    @(negedge clk); wr = 1; addr = 2'd0; wdata = 8'h01;
    @(negedge clk); idle();
    @(negedge clk); chk("R4 irq idle", {7'b0, irq}, 8'h00);
    s_ta = 1;
    @(negedge clk); idle(); #1;
    chk("R4 flag up", rdata & 8'h01, 8'h01);
    chk("R4 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 irq one clock later", {7'b0, irq}, 8'h01);

    // R1 reset again clears everything
    rst_n = 1'b0; #1;
    addr = 2'd0; #1; chk("R1 re-reset mask", rdata, 8'h00);
    addr = 2'd2; #1; chk("R1 re-reset stat", rdata, 8'h00);
    chk("R1 re-reset irq", {7'b0, irq}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule